// File: doc/BRIEF.md
# Direct-Mapped Data Cache Controller

This block is a direct-mapped data cache placed between a processor's load/store stage and main memory. It sees physical word addresses only. Each line holds one block of four 32-bit words, and a line is found by slicing the address into a tag, a line index, a word-in-block field and two byte bits that are always zero. The full-size configuration has 30 address bits and 13 index bits: 8192 lines, 128 KB of data and a 13-bit tag. The default parameters shrink the index to 6 bits so that the storage elaborates small. The tag then widens to 20 bits and the same logic applies.

The processor raises a request with a read/write flag, an address and write data, and holds them until the ready output is high at a clock edge. A parameter fixes the store policy. Under write-back, stores touch only the cache and mark the line dirty, and a dirty victim is copied out before a refill. Under write-through, every store also writes its word to memory. Under both policies a store that misses allocates: the block is fetched, then the store is retried as a hit. The memory side moves single words with a request/acknowledge handshake. A block takes four beats, lowest word first.

The controller is one state machine with four states:
- LOOKUP compares tags and serves hits. On a miss it goes to EVICT if the line is valid and dirty under write-back, and to REFILL otherwise. On a write-through store hit it goes to WTHRU.
- EVICT goes to REFILL after its fourth acknowledged beat.
- REFILL returns to LOOKUP after its fourth beat, where the held access is retried.
- WTHRU returns to LOOKUP on acknowledge.

Top module: `dcache_ctrl`

## Requirements
- R1: A hit needs the line's valid bit and a stored tag equal to address bits [ADDR_W-1:IDX_W+4]. The line is chosen by bits [IDX_W+3:4] and the word by bits [3:2]. A load hit returns that word with ready high in the same cycle and no memory traffic. Bits [1:0] of a requested address are zero.
- R2: Ready is low from the cycle a miss is detected until the retried access completes. The request inputs are held stable meanwhile.
- R3: A refill issues four read beats at byte addresses {request tag, index, beat, 2'b00}, with beat going 0, 1, 2, 3. It writes each returned word, sets the valid bit, installs the tag and clears the dirty bit. The retried access then hits.
- R4: A store that misses allocates under both policies. After the refill the stored word is readable by a later load with no further memory traffic.
- R5: In write-through mode a store writes the word into the cache and writes the same word to memory at its own address. Ready stays low until memory acknowledges that write.
- R6: In write-back mode a store hit updates only the cache, sets the line's dirty bit, completes in one cycle and causes no memory traffic.
- R7: In write-back mode a miss on a valid, dirty line first writes the four old words to {stored tag, index, beat, 2'b00}, beat 0 to 3. Only then does it start the refill.
- R8: In write-back mode a miss on a clean or invalid line issues no memory writes.
- R9: Reset clears every valid and dirty bit, so the first access to any line misses.
- R10: Memory request, direction, address and write data stay stable from the cycle a beat is requested until the cycle its one-cycle acknowledge is seen.
- R11: In write-through mode no block write-back ever occurs. A load miss causes exactly four read beats and no writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor access request |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Physical byte address, word aligned |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data, valid when ready is high on a load |
| cpu_ready | output | 1 | Access completes at this edge; low while stalled |
| mem_req | output | 1 | Memory beat request |
| mem_we | output | 1 | 1 = word write, 0 = word read |
| mem_addr | output | ADDR_W | Byte address of the beat |
| mem_wdata | output | 32 | Word written to memory |
| mem_rdata | input | 32 | Word read from memory, valid with acknowledge |
| mem_ack | input | 1 | One-cycle beat acknowledge |

## Verification
Two of this block's functions can fall in the same cycle: the acknowledge of the final write-back beat of a dirty victim, and the launch of the first refill beat for the new block. On that edge the memory request stays high while its direction and address switch. The bench provokes this overlap with repeated stores and loads to a few tags that share a line index, and with memory latency varied at random. The result is judged by comparing each load with a reference memory kept by the bench, by checking that the victim's words reach memory at the rebuilt address, and by counting read and write beats per access.

// File: rtl/dc_pkg.sv
package dc_pkg;
    typedef enum logic [1:0] {
        ST_LOOKUP = 2'd0,
        ST_EVICT  = 2'd1,
        ST_REFILL = 2'd2,
        ST_WTHRU  = 2'd3
    } dc_state_e;

    localparam int BEAT_W = 2;
    localparam int BYTE_W = 2;
endpackage

// File: rtl/dc_tag_store.sv
module dc_tag_store #(
    parameter int IDX_W = 6,
    parameter int TAG_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] new_tag,
    input  logic             install,
    input  logic             mark_dirty,
    output logic [TAG_W-1:0] line_tag,
    output logic             line_valid,
    output logic             line_dirty
);
    localparam int LINES = 2 ** IDX_W;

    logic [LINES-1:0] valid_q;
    logic [LINES-1:0] dirty_q;
    logic [TAG_W-1:0] tag_q [LINES];

    // reset clears all valid and dirty bits (R9)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
            dirty_q <= '0;
        end else if (install) begin
            valid_q[idx] <= 1'b1;
            dirty_q[idx] <= 1'b0;
        end else if (mark_dirty) begin
            dirty_q[idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (install) begin
            tag_q[idx] <= new_tag;
        end
    end

    assign line_tag   = tag_q[idx];
    assign line_valid = valid_q[idx];
    assign line_dirty = dirty_q[idx];
endmodule

// File: rtl/dc_data_store.sv
module dc_data_store #(
    parameter int IDX_W  = 6,
    parameter int WORD_W = 32
) (
    input  logic                      clk,
    input  logic [IDX_W-1:0]          idx,
    input  logic [dc_pkg::BEAT_W-1:0] rd_word,
    input  logic [dc_pkg::BEAT_W-1:0] ev_word,
    input  logic                      wr_en,
    input  logic [dc_pkg::BEAT_W-1:0] wr_word,
    input  logic [WORD_W-1:0]         wr_data,
    output logic [WORD_W-1:0]         rd_data,
    output logic [WORD_W-1:0]         ev_data
);
    localparam int DEPTH = 2 ** (IDX_W + dc_pkg::BEAT_W);

    logic [WORD_W-1:0] words_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            words_q[{idx, wr_word}] <= wr_data;
        end
    end

    assign rd_data = words_q[{idx, rd_word}];
    assign ev_data = words_q[{idx, ev_word}];
endmodule

// File: rtl/dc_fsm.sv
module dc_fsm
    import dc_pkg::*;
#(
    parameter int ADDR_W     = 30,
    parameter int IDX_W      = 6,
    parameter int WORD_W     = 32,
    parameter bit WRITE_BACK = 1'b1,
    localparam int TAG_W     = ADDR_W - IDX_W - BEAT_W - BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [TAG_W-1:0]  cpu_tag,
    input  logic [IDX_W-1:0]  cpu_idx,
    input  logic [BEAT_W-1:0] cpu_word,
    input  logic [WORD_W-1:0] cpu_wdata,
    input  logic              hit,
    input  logic              victim_valid,
    input  logic              victim_dirty,
    input  logic [TAG_W-1:0]  victim_tag,
    input  logic [WORD_W-1:0] ev_data,
    input  logic              mem_ack,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    output logic [BEAT_W-1:0] beat,
    output logic              dwr_en,
    output logic [BEAT_W-1:0] dwr_word,
    output logic [WORD_W-1:0] dwr_data,
    output logic              install,
    output logic              mark_dirty
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = '1;

    dc_state_e         state, state_nx;
    logic [BEAT_W-1:0] beat_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_LOOKUP;
            beat  <= '0;
        end else begin
            state <= state_nx;
            beat  <= beat_nx;
        end
    end

    always_comb begin
        state_nx   = state;
        beat_nx    = beat;
        cpu_ready  = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        mem_addr   = '0;
        mem_wdata  = '0;
        dwr_en     = 1'b0;
        dwr_word   = cpu_word;
        dwr_data   = cpu_wdata;
        install    = 1'b0;
        mark_dirty = 1'b0;
        unique case (state)
            ST_LOOKUP: begin
                if (!cpu_req) begin
                    cpu_ready = 1'b1;
                end else if (hit) begin
                    if (!cpu_we) begin
                        cpu_ready = 1'b1;
                    end else begin
                        dwr_en = 1'b1;
                        if (WRITE_BACK) begin
                            mark_dirty = 1'b1;
                            cpu_ready  = 1'b1;
                        end else begin
                            state_nx = ST_WTHRU;
                        end
                    end
                end else begin
                    beat_nx  = '0;
                    state_nx = (WRITE_BACK && victim_valid && victim_dirty)
                               ? ST_EVICT : ST_REFILL;
                end
            end
            ST_EVICT: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {victim_tag, cpu_idx, beat, {BYTE_W{1'b0}}};
                mem_wdata = ev_data;
                if (mem_ack) begin
                    beat_nx = beat + 1'b1;
                    if (beat == LAST_BEAT) begin
                        state_nx = ST_REFILL;
                    end
                end
            end
            ST_REFILL: begin
                mem_req  = 1'b1;
                mem_addr = {cpu_tag, cpu_idx, beat, {BYTE_W{1'b0}}};
                if (mem_ack) begin
                    dwr_en   = 1'b1;
                    dwr_word = beat;
                    dwr_data = mem_rdata;
                    beat_nx  = beat + 1'b1;
                    if (beat == LAST_BEAT) begin
                        install  = 1'b1;
                        state_nx = ST_LOOKUP;
                    end
                end
            end
            ST_WTHRU: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = {cpu_tag, cpu_idx, cpu_word, {BYTE_W{1'b0}}};
                mem_wdata = cpu_wdata;
                if (mem_ack) begin
                    cpu_ready = 1'b1;
                    state_nx  = ST_LOOKUP;
                end
            end
            default: state_nx = ST_LOOKUP;
        endcase
    end

    // R2: no completion while a block moves
    a_r2_stall_in_transfer: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EVICT || state == ST_REFILL) |-> !cpu_ready);

    // R3: the retried access hits after the last refill beat
    a_r3_retry_hits: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REFILL && mem_ack && beat == LAST_BEAT && cpu_req) |=> hit);

    // R7: the victim written back never carries the requested tag
    a_r7_victim_tag: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EVICT) |-> (mem_addr[ADDR_W-1 -: TAG_W] != cpu_tag));

    // R10: a pending beat holds its request, direction and address
    a_r10_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R6: a write-back store hit leaves memory untouched
    a_r6_wb_store_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (WRITE_BACK && state == ST_LOOKUP && cpu_req && cpu_we && hit) |-> (!mem_req && cpu_ready));

    // R11: write-through never enters the eviction state
    a_r11_no_evict: assert property (@(posedge clk) disable iff (!rst_n)
        (!WRITE_BACK && cpu_req) |-> (state != ST_EVICT));
endmodule

// File: rtl/dcache_ctrl.sv
module dcache_ctrl
    import dc_pkg::*;
#(
    parameter int ADDR_W     = 30,
    parameter int IDX_W      = 6,
    parameter int WORD_W     = 32,
    parameter bit WRITE_BACK = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [WORD_W-1:0] cpu_wdata,
    output logic [WORD_W-1:0] cpu_rdata,
    output logic              cpu_ready,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack
);
    localparam int OFF_W  = BEAT_W + BYTE_W;
    localparam int TAG_W  = ADDR_W - IDX_W - OFF_W;
    localparam int IDX_LO = OFF_W;
    localparam int TAG_LO = OFF_W + IDX_W;

    logic [TAG_W-1:0]  cpu_tag;
    logic [IDX_W-1:0]  cpu_idx;
    logic [BEAT_W-1:0] cpu_word;
    logic [TAG_W-1:0]  line_tag;
    logic              line_valid, line_dirty, hit;
    logic [WORD_W-1:0] ev_data;
    logic [BEAT_W-1:0] beat;
    logic              dwr_en, install, mark_dirty;
    logic [BEAT_W-1:0] dwr_word;
    logic [WORD_W-1:0] dwr_data;

    assign cpu_tag  = cpu_addr[ADDR_W-1:TAG_LO];
    assign cpu_idx  = cpu_addr[TAG_LO-1:IDX_LO];
    assign cpu_word = cpu_addr[IDX_LO-1:BYTE_W];
    assign hit      = line_valid && (line_tag == cpu_tag);

    dc_tag_store #(.IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (cpu_idx),
        .new_tag    (cpu_tag),
        .install    (install),
        .mark_dirty (mark_dirty),
        .line_tag   (line_tag),
        .line_valid (line_valid),
        .line_dirty (line_dirty)
    );

    dc_data_store #(.IDX_W(IDX_W), .WORD_W(WORD_W)) u_data (
        .clk     (clk),
        .idx     (cpu_idx),
        .rd_word (cpu_word),
        .ev_word (beat),
        .wr_en   (dwr_en),
        .wr_word (dwr_word),
        .wr_data (dwr_data),
        .rd_data (cpu_rdata),
        .ev_data (ev_data)
    );

    dc_fsm #(
        .ADDR_W     (ADDR_W),
        .IDX_W      (IDX_W),
        .WORD_W     (WORD_W),
        .WRITE_BACK (WRITE_BACK)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .cpu_tag      (cpu_tag),
        .cpu_idx      (cpu_idx),
        .cpu_word     (cpu_word),
        .cpu_wdata    (cpu_wdata),
        .hit          (hit),
        .victim_valid (line_valid),
        .victim_dirty (line_dirty),
        .victim_tag   (line_tag),
        .ev_data      (ev_data),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .cpu_ready    (cpu_ready),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .beat         (beat),
        .dwr_en       (dwr_en),
        .dwr_word     (dwr_word),
        .dwr_data     (dwr_data),
        .install      (install),
        .mark_dirty   (mark_dirty)
    );

    // R1: requests are word aligned
    a_r1_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_req |-> (cpu_addr[BYTE_W-1:0] == '0));
endmodule

// File: tb/tb_dcache_ctrl.sv
module tb_mem_model (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mem_req,
    input  logic        mem_we,
    input  logic [29:0] mem_addr,
    input  logic [31:0] mem_wdata,
    output logic        mem_ack,
    output logic [31:0] mem_rdata
);
    logic [31:0] store [logic [29:0]];
    int rd_beats  = 0;
    int wr_beats  = 0;
    int order_err = 0;
    int proto_err = 0;

    function automatic logic [31:0] peek(logic [29:0] a);
        if (store.exists(a)) return store[a];
        return ({2'b00, a} * 32'h9E3779B1) ^ 32'h5A5A_0F0F;
    endfunction

    initial begin
        logic [1:0]  rc;
        int          wait_cnt;
        logic        pend;
        logic [29:0] pend_addr;
        logic        pend_we;
        rc = '0; wait_cnt = 0; pend = 1'b0; pend_addr = '0; pend_we = 1'b0;
        mem_ack   = 1'b0;
        mem_rdata = '0;
        forever begin
            @(posedge clk);
            if (!rst_n) begin
                mem_ack <= 1'b0;
                pend = 1'b0;
            end else if (mem_ack) begin
                mem_ack <= 1'b0;
                pend = 1'b0;
            end else if (mem_req) begin
                if (pend && (mem_addr != pend_addr || mem_we != pend_we)) proto_err++;
                pend = 1'b1; pend_addr = mem_addr; pend_we = mem_we;
                if (wait_cnt == 0) begin
                    mem_ack <= 1'b1;
                    if (mem_we) begin
                        store[mem_addr] = mem_wdata;
                        wr_beats++;
                    end else begin
                        mem_rdata <= peek(mem_addr);
                        if (mem_addr[3:2] != rc) order_err++;
                        rc = rc + 2'd1;
                        rd_beats++;
                    end
                    wait_cnt = $urandom_range(2, 0);
                end else begin
                    wait_cnt--;
                end
            end else if (pend) begin
                proto_err++;
                pend = 1'b0;
            end
        end
    end
endmodule

module tb_dcache_ctrl;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic        req_a = 1'b0, req_b = 1'b0;
    logic        cpu_we = 1'b0;
    logic [29:0] cpu_addr = '0;
    logic [31:0] cpu_wdata = '0;
    logic [31:0] rdata_a, rdata_b;
    logic        ready_a, ready_b;
    logic        mreq_a, mwe_a, mack_a, mreq_b, mwe_b, mack_b;
    logic [29:0] maddr_a, maddr_b;
    logic [31:0] mwd_a, mrd_a, mwd_b, mrd_b;

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] gold [logic [29:0]];

    dcache_ctrl #(.WRITE_BACK(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .cpu_req(req_a), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(rdata_a),
        .cpu_ready(ready_a), .mem_req(mreq_a), .mem_we(mwe_a),
        .mem_addr(maddr_a), .mem_wdata(mwd_a), .mem_rdata(mrd_a), .mem_ack(mack_a));

    dcache_ctrl #(.WRITE_BACK(1'b0)) dut_wt (
        .clk(clk), .rst_n(rst_n), .cpu_req(req_b), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_rdata(rdata_b),
        .cpu_ready(ready_b), .mem_req(mreq_b), .mem_we(mwe_b),
        .mem_addr(maddr_b), .mem_wdata(mwd_b), .mem_rdata(mrd_b), .mem_ack(mack_b));

    tb_mem_model mem_a (.clk(clk), .rst_n(rst_n), .mem_req(mreq_a), .mem_we(mwe_a),
        .mem_addr(maddr_a), .mem_wdata(mwd_a), .mem_ack(mack_a), .mem_rdata(mrd_a));
    tb_mem_model mem_b (.clk(clk), .rst_n(rst_n), .mem_req(mreq_b), .mem_we(mwe_b),
        .mem_addr(maddr_b), .mem_wdata(mwd_b), .mem_ack(mack_b), .mem_rdata(mrd_b));

    function automatic logic [29:0] mk_addr(int tag, int idx, int word);
        return {tag[19:0], idx[5:0], word[1:0], 2'b00};
    endfunction

    function automatic logic [31:0] expect_word(logic [29:0] a);
        if (gold.exists(a)) return gold[a];
        return ({2'b00, a} * 32'h9E3779B1) ^ 32'h5A5A_0F0F;
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    int cyc_a, cyc_b;
    logic [31:0] got_a, got_b;

    task automatic op(input bit we, input logic [29:0] a, input logic [31:0] d);
        bit done_a, done_b;
        done_a = 1'b0; done_b = 1'b0; cyc_a = 0; cyc_b = 0;
        cpu_we = we; cpu_addr = a; cpu_wdata = d;
        req_a = 1'b1; req_b = 1'b1;
        while (!(done_a && done_b)) begin
            @(negedge clk);
            if (!done_a) begin
                cyc_a++;
                if (ready_a) begin got_a = rdata_a; done_a = 1'b1; end
            end
            if (!done_b) begin
                cyc_b++;
                if (ready_b) begin got_b = rdata_b; done_b = 1'b1; end
            end
            @(posedge clk); #1;
            if (done_a) req_a = 1'b0;
            if (done_b) req_b = 1'b0;
        end
        if (we) gold[a] = d;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL R2 watchdog expired: actual %0d expected %0d", 1, 0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int ra, wa, rb, wb;
        logic [29:0] x, y, z, k;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk); #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R9 reset state
        chk(ready_a && ready_b && !mreq_a && !mreq_b, "R9", "idle after reset",
            {ready_a, ready_b, mreq_a, mreq_b}, 4'b1100);
        @(posedge clk); #1;

        x = mk_addr(5, 1, 1); y = mk_addr(9, 1, 2); z = mk_addr(3, 2, 3);

        ra = mem_a.rd_beats; rb = mem_b.rd_beats;
        op(1'b0, x, '0);
        chk(mem_a.rd_beats - ra == 4, "R9", "first load misses (wb)", mem_a.rd_beats - ra, 4);
        chk(mem_b.rd_beats - rb == 4, "R11", "load miss four reads (wt)", mem_b.rd_beats - rb, 4);
        chk(got_a == expect_word(x), "R3", "refilled word (wb)", got_a, expect_word(x));
        chk(got_b == expect_word(x), "R3", "refilled word (wt)", got_b, expect_word(x));
        chk(cyc_a > 4, "R2", "stall on miss", cyc_a, 5);

        ra = mem_a.rd_beats; rb = mem_b.rd_beats;
        op(1'b0, mk_addr(5, 1, 3), '0);
        chk(cyc_a == 1 && cyc_b == 1, "R1", "hit in one cycle", {cyc_a[15:0], cyc_b[15:0]}, 32'h0001_0001);
        chk(mem_a.rd_beats == ra && mem_b.rd_beats == rb, "R1", "hit no traffic", mem_a.rd_beats - ra, 0);
        chk(got_a == expect_word(mk_addr(5, 1, 3)), "R1", "hit word", got_a, expect_word(mk_addr(5, 1, 3)));

        wa = mem_a.wr_beats; wb = mem_b.wr_beats;
        op(1'b1, x, 32'hCAFE_0001);
        chk(mem_a.wr_beats == wa && cyc_a == 1, "R6", "wb store hit quiet", mem_a.wr_beats - wa, 0);
        chk(mem_a.peek(x) != 32'hCAFE_0001, "R6", "memory stale under wb", mem_a.peek(x), 32'h0);
        chk(mem_b.wr_beats - wb == 1, "R5", "wt store one write", mem_b.wr_beats - wb, 1);
        chk(mem_b.peek(x) == 32'hCAFE_0001, "R5", "wt memory word", mem_b.peek(x), 32'hCAFE_0001);
        chk(cyc_b > 1, "R5", "wt store stalls", cyc_b, 2);

        ra = mem_a.rd_beats; wa = mem_a.wr_beats; rb = mem_b.rd_beats; wb = mem_b.wr_beats;
        op(1'b0, y, '0);
        chk(mem_a.wr_beats - wa == 4 && mem_a.rd_beats - ra == 4, "R7", "dirty victim beats",
            mem_a.wr_beats - wa, 4);
        chk(mem_a.peek(x) == 32'hCAFE_0001, "R7", "victim at rebuilt address", mem_a.peek(x), 32'hCAFE_0001);
        chk(mem_b.wr_beats == wb && mem_b.rd_beats - rb == 4, "R11", "wt no write-back",
            mem_b.wr_beats - wb, 0);
        chk(got_a == expect_word(y) && got_b == expect_word(y), "R3", "conflict load data", got_a, expect_word(y));

        ra = mem_a.rd_beats; wa = mem_a.wr_beats;
        op(1'b0, x, '0);
        chk(mem_a.wr_beats == wa && mem_a.rd_beats - ra == 4, "R8", "clean victim no writes",
            mem_a.wr_beats - wa, 0);
        chk(got_a == 32'hCAFE_0001 && got_b == 32'hCAFE_0001, "R8", "reloaded stored word", got_a, 32'hCAFE_0001);

        ra = mem_a.rd_beats; rb = mem_b.rd_beats; wb = mem_b.wr_beats;
        op(1'b1, z, 32'h1234_5678);
        chk(mem_a.rd_beats - ra == 4 && mem_b.rd_beats - rb == 4, "R4", "store miss allocates",
            mem_a.rd_beats - ra, 4);
        chk(mem_b.wr_beats - wb == 1, "R4", "wt store miss word write", mem_b.wr_beats - wb, 1);
        ra = mem_a.rd_beats; rb = mem_b.rd_beats;
        op(1'b0, z, '0);
        chk(got_a == 32'h1234_5678 && got_b == 32'h1234_5678 && mem_a.rd_beats == ra
            && mem_b.rd_beats == rb, "R4", "allocated store hit", got_a, 32'h1234_5678);

        for (int i = 0; i < 400; i++) begin
            logic [29:0] a;
            bit w;
            a = mk_addr($urandom_range(2, 0) * 7 + 1, $urandom_range(3, 0), $urandom_range(3, 0));
            w = $urandom_range(1, 0);
            op(w, a, $urandom);
            if (!w) begin
                chk(got_a == expect_word(a), "R7", "random load wb", got_a, expect_word(a));
                chk(got_b == expect_word(a), "R5", "random load wt", got_b, expect_word(a));
            end
        end

        if (gold.first(k)) begin
            do begin
                chk(mem_b.peek(k) == gold[k], "R5", "wt memory consistent", mem_b.peek(k), gold[k]);
            end while (gold.next(k));
        end
        chk(mem_a.order_err == 0 && mem_b.order_err == 0, "R3", "beats lowest word first",
            mem_a.order_err + mem_b.order_err, 0);
        chk(mem_a.proto_err == 0 && mem_b.proto_err == 0, "R10", "beat held until ack",
            mem_a.proto_err + mem_b.proto_err, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule